// File: doc/BRIEF.md
# Conversion-Synchronized Sample Strobe Generator

This block gives external circuitry one timed pulse for every analog-to-digital conversion start. It watches an active-low conversion command. When that command falls, the block waits a fixed number of clock cycles and then drives a pulse of fixed width on its strobe output. An external analog multiplexer can use the leading edge as a clock. The edge tells the multiplexer that the present input has been sampled and that the channel may change.

Two register bits from outside control the output. An enable bit allows pulses. A polarity bit selects which level is active. The command input is asynchronous, so it passes through a synchronizer chain before edge detection. The chain latency is taken out of the wait, so the total delay from the command to the leading edge is exactly `DELAY_CYC` clocks. The defaults are 8 cycles of delay and 45 cycles of width, which at 100 MHz gives 80 ns and 450 ns.

The sequencer has three states. IDLE is the rest state: the output is inactive and the block waits for a command edge. WAIT counts out the delay. DRIVE holds the output at its active level. The transitions are:
- IDLE to WAIT on a detected falling edge while enabled.
- WAIT to DRIVE when the delay count expires.
- DRIVE to IDLE when the width count expires.
- WAIT or DRIVE to IDLE at once when enable is low.

Top module: `conv_strobe_gen`

## Requirements
- R1: While `rst` is high and on the first cycles after it, the sequencer is in IDLE. With `strb_en`=0 and `strb_inv`=0 the output `strb_out` is 0.
- R2: Each high-to-low transition of `cnv_cmd_n` seen while enabled and IDLE starts exactly one pulse. This holds whether the low phase lasts one clock or many.
- R3: The leading edge of the pulse appears on the clock edge `DELAY_CYC` edges after the first rising clock edge that samples `cnv_cmd_n` low.
- R4: The output stays at its active level for exactly `WIDTH_CYC` clock cycles, then returns to its inactive level.
- R5: The active level is selected by `strb_inv`: 0 means active high (rising leading edge), 1 means active low. The inactive level equals `strb_inv`.
- R6: While `strb_en`=0 the output sits at its inactive level and command edges produce no pulse, either then or later.
- R7: A command edge that arrives while a pulse is waiting (WAIT) or being driven (DRIVE) is ignored. Pulses never merge or stretch.
- R8: Clearing `strb_en` during DRIVE returns the output to its inactive level in the same cycle. Clearing it during WAIT drops the pending pulse. Neither pulse resumes when enable is set again.
- R9: The sequencer moves IDLE to WAIT on an accepted edge, WAIT to DRIVE when the delay count ends, and DRIVE to IDLE when the width count ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnv_cmd_n | input | 1 | Conversion command, active low, asynchronous |
| strb_en | input | 1 | Register bit that allows pulses |
| strb_inv | input | 1 | Register bit that selects an active-low output |
| strb_out | output | 1 | Sample strobe output |

## Verification
Some properties are checked on every cycle:
- While disabled, the output equals its inactive level.
- An active phase never runs longer than `WIDTH_CYC`.
- DRIVE is entered only from WAIT.
- Every accepted edge moves the sequencer from IDLE to WAIT.

The exact leading-edge cycle and the exact width are shown only by the bench's scoreboard. The same holds for edges ignored while busy, for cancellation in either busy state, and for the inverted polarity. In each case the scoreboard compares observed pulse starts and widths against the times when the commands were issued.

// File: rtl/sstr_pkg.sv
package sstr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRIVE = 2'd2
    } state_t;
endpackage

// File: rtl/sstr_sync_edge.sv
// Synchronizer chain followed by a falling-edge detector.
module sstr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_n,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din_n;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/sstr_timer.sv
// Cycle counter shared by the WAIT and DRIVE phases.
module sstr_timer #(
    parameter int WAIT_CYC  = 6,
    parameter int WIDTH_CYC = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic wait_done,
    output logic drive_done
);
    localparam int MAXC = (WAIT_CYC > WIDTH_CYC) ? WAIT_CYC : WIDTH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    assign wait_done  = (cnt == CW'(WAIT_CYC - 1));
    assign drive_done = (cnt == CW'(WIDTH_CYC - 1));
endmodule

// File: rtl/sstr_fsm.sv
// Three-state sequencer: rest, delay count, active drive.
module sstr_fsm
    import sstr_pkg::*;
#(
    parameter int WAIT_CYC  = 6,
    parameter int WIDTH_CYC = 45
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fall,
    input  logic   en,
    output state_t state
);
    state_t nxt;
    logic   wait_done;
    logic   drive_done;

    sstr_timer #(
        .WAIT_CYC (WAIT_CYC),
        .WIDTH_CYC(WIDTH_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr       (state != nxt),
        .run       (state != ST_IDLE),
        .wait_done (wait_done),
        .drive_done(drive_done)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (fall && en) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (!en)            nxt = ST_IDLE;
                else if (wait_done) nxt = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!en || drive_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sstr_outstage.sv
// Output level: active only in DRIVE with enable high, then polarity applied.
module sstr_outstage
    import sstr_pkg::*;
(
    input  state_t state,
    input  logic   en,
    input  logic   inv,
    output logic   strobe
);
    always_comb begin
        strobe = ((state == ST_DRIVE) && en) ^ inv;
    end
endmodule

// File: rtl/conv_strobe_gen.sv
module conv_strobe_gen
    import sstr_pkg::*;
#(
    parameter int DELAY_CYC   = 8,
    parameter int WIDTH_CYC   = 45,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cnv_cmd_n,
    input  logic strb_en,
    input  logic strb_inv,
    output logic strb_out
);
    // The synchronizer and the IDLE->WAIT edge together take SYNC_STAGES clocks.
    localparam int WAIT_CYC = DELAY_CYC - SYNC_STAGES;

    logic   cmd_fall;
    state_t state;

    sstr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din_n(cnv_cmd_n),
        .fall (cmd_fall)
    );

    sstr_fsm #(
        .WAIT_CYC (WAIT_CYC),
        .WIDTH_CYC(WIDTH_CYC)
    ) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .fall (cmd_fall),
        .en   (strb_en),
        .state(state)
    );

    sstr_outstage u_out (
        .state (state),
        .en    (strb_en),
        .inv   (strb_inv),
        .strobe(strb_out)
    );
endmodule

// File: rtl/sstr_chk.sv
module sstr_chk
    import sstr_pkg::*;
#(
    parameter int WIDTH_CYC = 45
) (
    input logic   clk,
    input logic   rst,
    input logic   en,
    input logic   inv,
    input logic   strobe,
    input state_t state,
    input logic   fall
);
    logic         rst_q;
    logic [15:0]  act_run;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                 act_run <= '0;
        else if (strobe != inv)  act_run <= act_run + 1'b1;
        else                     act_run <= '0;
    end

    // R1: sequencer rests in IDLE right after reset
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            a_r1_idle_after_reset: assert (state == ST_IDLE);
    end

    // R4: an active phase never exceeds the programmed width
    always_ff @(posedge clk) begin
        if (!rst)
            a_r4_width_max: assert (act_run <= 16'(WIDTH_CYC));
    end

    a_r6_disabled_inactive: assert property (@(posedge clk) disable iff (rst)
        !en |-> (strobe == inv));

    a_r9_drive_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_DRIVE) |-> $past(state == ST_WAIT));

    a_r2_accept_edge: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fall && en) |=> (state == ST_WAIT));

    a_r7_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRIVE && en && fall) |=> (state != ST_WAIT));
endmodule

bind conv_strobe_gen sstr_chk #(.WIDTH_CYC(WIDTH_CYC)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (strb_en),
    .inv   (strb_inv),
    .strobe(strb_out),
    .state (state),
    .fall  (cmd_fall)
);

// File: tb/test_conv_strobe_gen.sv
module test_conv_strobe_gen;
    localparam int DLY = 8;
    localparam int WID = 45;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnv_cmd_n = 1'b1;
    logic strb_en = 1'b0;
    logic strb_inv = 1'b0;
    logic strb_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pulses = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    conv_strobe_gen #(.DELAY_CYC(DLY), .WIDTH_CYC(WID)) i_conv_strobe_gen (
        .clk(clk), .rst(rst), .cnv_cmd_n(cnv_cmd_n),
        .strb_en(strb_en), .strb_inv(strb_inv), .strb_out(strb_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: issue a command at posedge+1; push expected start when one is due.
    task automatic convert(input int low_cyc, input bit expect_pulse);
        @(posedge clk); #1;
        cnv_cmd_n = 1'b0;
        if (expect_pulse) exp_q.push_back(cyc + DLY + 1);
        repeat (low_cyc) @(posedge clk);
        #1 cnv_cmd_n = 1'b1;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor / scoreboard
    bit act_prev = 1'b0;
    int run_len  = 0;
    always @(negedge clk) begin
        bit act;
        act = (strb_out != strb_inv);
        if (mon_on) begin
            if (act && !act_prev) begin
                pulses++;
                run_len = 1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R7 unexpected pulse", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R3 leading edge cycle", cyc, e);
                end
            end else if (act) begin
                run_len++;
            end else if (act_prev) begin
                check(run_len == WID, "R4 pulse width", run_len, WID);
            end
        end
        act_prev = act;
    end

    initial begin
        int p0;
        repeat (5) @(posedge clk);
        #1;
        check(strb_out == 1'b0, "R1 output in reset", strb_out, 0);
        rst = 1'b0;
        idle_cycles(3);
        check(strb_out == 1'b0, "R1 output after reset", strb_out, 0);

        // R5/R6: inactive level follows polarity while disabled
        strb_inv = 1'b1; #1;
        check(strb_out == 1'b1, "R5 inactive level inverted", strb_out, 1);
        strb_inv = 1'b0; #1;
        check(strb_out == 1'b0, "R5 inactive level normal", strb_out, 0);
        mon_on = 1'b1;

        // R6: disabled commands are ignored, now and later
        p0 = pulses;
        convert(3, 1'b0);
        idle_cycles(20);
        strb_en = 1'b1;
        idle_cycles(60);
        check(pulses == p0, "R6 no pulse while disabled", pulses - p0, 0);
        check(strb_out == 1'b0, "R6 inactive after enable", strb_out, 0);

        // R2/R3/R4: short and long command lows
        p0 = pulses;
        convert(1, 1'b1);
        idle_cycles(70);
        convert(25, 1'b1);
        idle_cycles(70);
        check(pulses - p0 == 2, "R2 one pulse per command", pulses - p0, 2);

        // R5: active-low output
        strb_inv = 1'b1;
        idle_cycles(2);
        check(strb_out == 1'b1, "R5 idle level high when inverted", strb_out, 1);
        p0 = pulses;
        convert(2, 1'b1);
        idle_cycles(DLY + 5);
        check(strb_out == 1'b0, "R5 active level low when inverted", strb_out, 0);
        idle_cycles(70);
        check(pulses - p0 == 1, "R5 inverted pulse count", pulses - p0, 1);
        strb_inv = 1'b0;
        idle_cycles(2);

        // R7: commands during WAIT and DRIVE are ignored
        p0 = pulses;
        convert(2, 1'b1);
        idle_cycles(1);
        convert(1, 1'b0);          // lands in WAIT
        idle_cycles(15);
        convert(1, 1'b0);          // lands in DRIVE
        idle_cycles(80);
        check(pulses - p0 == 1, "R7 busy commands ignored", pulses - p0, 1);

        // R9: back-to-back accepted after return to IDLE
        p0 = pulses;
        convert(1, 1'b1);
        idle_cycles(DLY + WID + 2);
        convert(1, 1'b1);
        idle_cycles(70);
        check(pulses - p0 == 2, "R9 sequence repeats", pulses - p0, 2);

        // R8: clear enable mid-pulse
        mon_on = 1'b0;
        convert(1, 1'b0);
        idle_cycles(DLY + 10);
        check(strb_out == 1'b1, "R8 pulse active before clear", strb_out, 1);
        strb_en = 1'b0; #1;
        check(strb_out == 1'b0, "R8 cleared at once", strb_out, 0);
        idle_cycles(3);
        strb_en = 1'b1;
        idle_cycles(1);
        check(strb_out == 1'b0, "R8 no resume after re-enable", strb_out, 0);
        idle_cycles(60);
        act_prev = 1'b0;
        mon_on = 1'b1;

        // R8: clear enable during WAIT drops the pulse
        p0 = pulses;
        convert(1, 1'b0);
        idle_cycles(3);
        strb_en = 1'b0;
        idle_cycles(1);
        strb_en = 1'b1;
        idle_cycles(70);
        check(pulses == p0, "R8 pending pulse dropped", pulses - p0, 0);

        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule